// File: doc/BRIEF.md
# UART Data and Status Register Front End

This block connects a simple register bus to a serial line. One data address serves both directions: a bus write places a byte into the transmit holding buffer, and a bus read takes the oldest received character out of a two-entry receive queue. A status register reports whether received data is waiting, whether the last transmission has fully finished, whether the holding buffer can take another byte, and the per-character framing result and overrun condition. A control register holds the three interrupt enables, the receiver and transmitter enables and the character length.

The serial side uses a fixed bit time of `CLKS_PER_BIT` clocks. Each frame has one low start bit, 5 to 8 data bits sent least significant first, and one high stop bit. There is no parity. The receiver finds a start bit on a falling edge, checks it again half a bit later, and then samples each later bit in its middle.

Register map (the `bus_addr` value selects it): 0 = data, 1 = status, 2 = control. Status bits: 7 receive-complete, 6 transmit-complete, 5 buffer-empty, 4 frame error of the queue head, 3 overrun, 2 parity error (always 0); bits 1:0 read 0. Control bits: 7 receive-complete interrupt enable, 6 transmit-complete interrupt enable, 5 buffer-empty interrupt enable, 4 receiver enable, 3 transmitter enable, 2 spare (read/write), 1:0 character length (00 = 5, 01 = 6, 10 = 7, 11 = 8 bits).

Top module: `uart_regfront`

## Requirements
- R1: After reset, status reads 0x20, control reads 0x00 and `tx_o` is high. A write to address 0 loads the transmit buffer. A read of address 0 returns the head of the receive queue, or 0x00 when the queue is empty.
- R2: A write to address 0 while the buffer-empty flag (status bit 5) is 0 is ignored: the byte already held is the one that gets sent.
- R3: With control bit 3 set and the shifter idle, a held byte is sent as one low start bit, the data bits least significant first and one high stop bit, each `CLKS_PER_BIT` clocks long. The line is high when idle.
- R4: Control bits 1:0 choose 5, 6, 7 or 8 data bits. The transmitter sends only that many low bits of the byte, and the receiver returns the unused upper bits as 0.
- R5: The receive queue holds two characters, and each read of address 0 removes the head. A character that completes while two are queued is dropped and sets overrun (status bit 3). The next read of address 0 clears overrun.
- R6: Receive-complete (status bit 7) is 1 exactly while the queue is non-empty. Clearing control bit 4 empties the queue.
- R7: Transmit-complete (status bit 6) is set when a stop bit ends and no byte is waiting in the buffer. Writing 1 to status bit 6, or a one-cycle `txc_ack` pulse, clears it.
- R8: Buffer-empty (status bit 5) is 1 out of reset and 0 while the buffer holds a byte that the shifter has not yet taken.
- R9: Status bit 4 is 1 when the character at the head of the queue was received with a low stop bit, and 0 otherwise.
- R10: `irq_rxc`, `irq_txc` and `irq_dre` are high exactly when the matching flag and its enable (control bits 7, 6, 5) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| txc_ack | input | 1 | Interrupt acknowledge that clears transmit-complete |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| irq_rxc | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_dre | output | 1 | Buffer-empty interrupt request |

## Verification
The assertions assume that each bus access lasts a single cycle and that `txc_ack` is a single-cycle pulse. They also assume that `rx_i` stays steady for a whole bit time, so that a frame looks the same whichever clock the synchronizer samples it on. The bench drives the bus only on falling clock edges and holds every access for exactly one cycle. It builds receive frames bit by bit from whole multiples of `CLKS_PER_BIT`, and it changes the control register only between frames, never while a character is being shifted.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;

  typedef struct packed {
    logic       ferr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    SH_IDLE  = 2'd0,
    SH_START = 2'd1,
    SH_DATA  = 2'd2,
    SH_STOP  = 2'd3
  } shift_state_t;
endpackage

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
  import uart_rf_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_data,
  input  logic [2:0] last_idx,
  output logic       busy,
  output logic       done,
  output logic       tx
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] BIT_END = CW'(CLKS_PER_BIT - 1);

  shift_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          done_d;
  logic          bit_end;

  assign bit_end = (cnt_q == BIT_END);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    done_d = 1'b0;
    if (st_q != SH_IDLE) cnt_d = bit_end ? '0 : cnt_q + 1'b1;
    case (st_q)
      SH_IDLE: if (load) begin
        st_d  = SH_START;
        cnt_d = '0;
        sh_d  = load_data;
      end
      SH_START: if (bit_end) begin
        st_d  = SH_DATA;
        idx_d = '0;
      end
      SH_DATA: if (bit_end) begin
        sh_d  = {1'b0, sh_q[7:1]};
        idx_d = idx_q + 1'b1;
        if (idx_q == last_idx) st_d = SH_STOP;
      end
      SH_STOP: if (bit_end) begin
        st_d   = SH_IDLE;
        done_d = 1'b1;
      end
      default: st_d = SH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SH_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      sh_q  <= '0;
      done  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      sh_q  <= sh_d;
      done  <= done_d;
    end
  end

  assign busy = (st_q != SH_IDLE);
  assign tx   = (st_q == SH_START) ? 1'b0 : (st_q == SH_DATA) ? sh_q[0] : 1'b1;

  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx); // R3
  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> !tx); // R3
endmodule

// File: rtl/uart_rx_shifter.sv
module uart_rx_shifter
  import uart_rf_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      rx,
  input  logic [2:0] last_idx,
  output logic      valid,
  output rx_entry_t entry
);
  localparam int CW = (CLKS_PER_BIT > 2) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] BIT_END  = CW'(CLKS_PER_BIT - 1);
  localparam logic [CW-1:0] HALF_END = CW'(CLKS_PER_BIT / 2 - 1);

  logic s1_q, s2_q, prev_q;
  shift_state_t st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    idx_q, idx_d;
  logic [7:0]    sh_q, sh_d;
  logic          valid_d;
  rx_entry_t     ent_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q + 1'b1;
    idx_d   = idx_q;
    sh_d    = sh_q;
    valid_d = 1'b0;
    ent_d   = entry;
    case (st_q)
      SH_IDLE: begin
        cnt_d = '0;
        if (prev_q && !s2_q) st_d = SH_START;
      end
      SH_START: if (cnt_q == HALF_END) begin
        cnt_d = '0;
        idx_d = '0;
        sh_d  = '0;
        st_d  = s2_q ? SH_IDLE : SH_DATA;
      end
      SH_DATA: if (cnt_q == BIT_END) begin
        cnt_d        = '0;
        sh_d[idx_q]  = s2_q;
        idx_d        = idx_q + 1'b1;
        if (idx_q == last_idx) st_d = SH_STOP;
      end
      SH_STOP: if (cnt_q == BIT_END) begin
        st_d       = SH_IDLE;
        valid_d    = 1'b1;
        ent_d.data = sh_q;
        ent_d.ferr = !s2_q;
      end
      default: st_d = SH_IDLE;
    endcase
    if (!enable) begin
      st_d    = SH_IDLE;
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
      st_q   <= SH_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      valid  <= 1'b0;
      entry  <= '0;
    end else begin
      s1_q   <= rx;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      valid  <= valid_d;
      entry  <= ent_d;
    end
  end

  AST_RX_NO_PUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !valid); // R6
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         not_empty,
  output logic         overflow
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, do_push, do_pop;

  assign full      = (cnt_q == FULL_CNT);
  assign not_empty = (cnt_q != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign overflow  = push && full && !do_pop && !flush;
  assign head      = not_empty ? mem_q[rp_q] : '0;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST_PTR) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST_PTR) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
    if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    if (flush) begin
      wp_d  = '0;
      rp_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else if (do_push && !flush && wp_q == PW'(g)) mem_q[g] <= push_data;
    end
  end

  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT); // R5
  AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !not_empty); // R6
  AST_FIFO_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> full); // R5
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int CLKS_PER_BIT = 16,
  parameter int RX_DEPTH     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       txc_ack,
  input  logic       rx_i,
  output logic       tx_o,
  output logic       irq_rxc,
  output logic       irq_txc,
  output logic       irq_dre
);
  localparam int EW = $bits(rx_entry_t);

  logic [7:0] ctrl_q, ctrl_d;
  logic [7:0] tbuf_q, tbuf_d;
  logic       tfull_q, tfull_d;
  logic       txc_q, txc_d;
  logic       ovr_q, ovr_d;

  logic       wr_data, rd_data, wr_stat, wr_ctrl;
  logic       tx_busy, tx_done, tx_load;
  logic       rx_valid, rx_flush, fifo_ovf, rxc;
  rx_entry_t  rx_ent, head;
  logic [EW-1:0] head_raw;
  logic [2:0] last_idx;
  logic       dre;

  assign wr_data  = bus_sel && bus_wr && bus_addr == ADDR_DATA;
  assign rd_data  = bus_sel && !bus_wr && bus_addr == ADDR_DATA;
  assign wr_stat  = bus_sel && bus_wr && bus_addr == ADDR_STAT;
  assign wr_ctrl  = bus_sel && bus_wr && bus_addr == ADDR_CTRL;
  assign last_idx = {1'b1, ctrl_q[1:0]};
  assign dre      = !tfull_q;
  assign tx_load  = ctrl_q[3] && tfull_q && !tx_busy;
  assign rx_flush = !ctrl_q[4];
  assign head     = rx_entry_t'(head_raw);

  always_comb begin
    ctrl_d  = wr_ctrl ? bus_wdata : ctrl_q;
    tbuf_d  = tbuf_q;
    tfull_d = tfull_q;
    if (tx_load) tfull_d = 1'b0;
    if (wr_data && dre) begin
      tbuf_d  = bus_wdata;
      tfull_d = 1'b1;
    end
    txc_d = txc_q;
    if (tx_done && !tfull_q) txc_d = 1'b1;
    if (txc_ack || (wr_stat && bus_wdata[6])) txc_d = 1'b0;
    ovr_d = ovr_q;
    if (rd_data) ovr_d = 1'b0;
    if (fifo_ovf) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      tbuf_q  <= '0;
      tfull_q <= 1'b0;
      txc_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      tbuf_q  <= tbuf_d;
      tfull_q <= tfull_d;
      txc_q   <= txc_d;
      ovr_q   <= ovr_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_DATA: bus_rdata = head.data;
      ADDR_STAT: bus_rdata = {rxc, txc_q, dre, head.ferr, ovr_q, 3'b000};
      ADDR_CTRL: bus_rdata = ctrl_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_rxc = rxc && ctrl_q[7];
  assign irq_txc = txc_q && ctrl_q[6];
  assign irq_dre = dre && ctrl_q[5];

  uart_tx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_data(tbuf_q),
    .last_idx(last_idx), .busy(tx_busy), .done(tx_done), .tx(tx_o)
  );

  uart_rx_shifter #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
    .clk(clk), .rst_n(rst_n), .enable(ctrl_q[4]), .rx(rx_i),
    .last_idx(last_idx), .valid(rx_valid), .entry(rx_ent)
  );

  uart_rx_fifo #(.DEPTH(RX_DEPTH), .W(EW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_valid),
    .push_data(rx_ent), .pop(rd_data), .head(head_raw),
    .not_empty(rxc), .overflow(fifo_ovf)
  );

  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && !dre) |=> $stable(tbuf_q)); // R2
  AST_TXC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    txc_ack |=> !txc_q); // R7
  AST_DRE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && dre && !ctrl_q[3]) |=> !dre); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ovf |=> ovr_q); // R5
endmodule

// File: tb/uart_regfront_tb.sv
module uart_regfront_tb;
  localparam int CPB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, txc_ack = 1'b0, rx_i = 1'b1;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       tx_o, irq_rxc, irq_txc, irq_dre;

  int nvec = 0, nerr = 0;
  int cur_bits = 8;
  logic [7:0] txq[$];
  logic [8:0] rxq[$];
  logic [7:0] rd;

  always #10 clk = ~clk;

  uart_regfront #(.CLKS_PER_BIT(CPB), .RX_DEPTH(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txc_ack(txc_ack), .rx_i(rx_i), .tx_o(tx_o), .irq_rxc(irq_rxc),
    .irq_txc(irq_txc), .irq_dre(irq_dre)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  // driver: send a byte, expecting it on the line (masked to cur_bits)
  task automatic send_byte(input logic [7:0] d);
    txq.push_back(d & 8'((1 << cur_bits) - 1));
    bus_write(2'd0, d);
  endtask

  // driver: a frame on rx_i; keep=1 pushes the expected entry
  task automatic rx_frame(input logic [7:0] d, input logic stop, input logic keep);
    if (keep) rxq.push_back({!stop, d & 8'((1 << cur_bits) - 1)});
    rx_i = 1'b0; repeat (CPB) @(posedge clk);
    for (int i = 0; i < cur_bits; i++) begin
      rx_i = d[i]; repeat (CPB) @(posedge clk);
    end
    rx_i = stop; repeat (CPB) @(posedge clk);
    rx_i = 1'b1; repeat (CPB) @(posedge clk);
  endtask

  task automatic pop_check(input string req);
    logic [8:0] e;
    logic [7:0] st, d;
    e = rxq.pop_front();
    bus_read(2'd1, st);
    check({req, " R9 head frame error"}, {7'd0, st[4]}, {7'd0, e[8]});
    bus_read(2'd0, d);
    check({req, " R1 data read"}, d, e[7:0]);
  endtask

  task automatic wait_tx_idle();
    wait (txq.size() == 0);
    repeat (2 * CPB) @(posedge clk);
  endtask

  // monitor: decodes tx_o and compares with the scoreboard queue
  initial begin
    @(posedge rst_n);
    forever begin
      logic [7:0] got;
      logic [7:0] exp;
      @(negedge tx_o);
      got = '0;
      repeat (CPB / 2) @(posedge clk);
      for (int i = 0; i < cur_bits; i++) begin
        repeat (CPB) @(posedge clk);
        #1 got[i] = tx_o;
      end
      repeat (CPB) @(posedge clk);
      #1 check("R3 stop bit", {7'd0, tx_o}, 8'd1);
      exp = (txq.size() != 0) ? txq.pop_front() : 8'hxx;
      check("R3 R4 transmitted byte", got, exp);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bus_read(2'd1, v); check("R1 R8 status reset", v, 8'h20);
    bus_read(2'd2, v); check("R1 control reset", v, 8'h00);
    check("R3 idle line", {7'd0, tx_o}, 8'd1);
    check("R10 irqs off at reset", {5'd0, irq_rxc, irq_txc, irq_dre}, 8'd0);

    // enables on, tx off, 8 bits
    bus_write(2'd2, 8'hF3);
    #1 check("R10 dre irq", {7'd0, irq_dre}, 8'd1);
    send_byte(8'h11);
    bus_read(2'd1, v); check("R8 dre low with byte held", {7'd0, v[5]}, 8'd0);
    check("R10 dre irq follows flag", {7'd0, irq_dre}, 8'd0);
    bus_write(2'd0, 8'h22);                 // R2: must be ignored
    bus_write(2'd2, 8'hFB);                 // tx enable
    wait_tx_idle();
    bus_read(2'd1, v); check("R7 txc set", {7'd0, v[6]}, 8'd1);
    check("R10 txc irq", {7'd0, irq_txc}, 8'd1);
    bus_write(2'd1, 8'h40);
    bus_read(2'd1, v); check("R7 txc write-one clear", {7'd0, v[6]}, 8'd0);

    send_byte(8'hA5);
    send_byte(8'h3C);                       // waits in buffer during frame
    wait_tx_idle();
    bus_read(2'd1, v); check("R7 txc after back-to-back", {7'd0, v[6]}, 8'd1);
    @(negedge clk) txc_ack = 1'b1;
    @(negedge clk) txc_ack = 1'b0;
    bus_read(2'd1, v); check("R7 txc ack clear", {7'd0, v[6]}, 8'd0);

    // 5-bit characters
    bus_write(2'd2, 8'hF8);
    cur_bits = 5;
    send_byte(8'hEA);
    wait_tx_idle();
    rx_frame(8'h15, 1'b1, 1'b1);
    bus_read(2'd1, v); check("R6 rxc set", {7'd0, v[7]}, 8'd1);
    check("R10 rxc irq", {7'd0, irq_rxc}, 8'd1);
    pop_check("R4 five-bit receive");

    // 8-bit, fifo depth, overrun
    bus_write(2'd2, 8'hFB);
    cur_bits = 8;
    rx_frame(8'h5A, 1'b1, 1'b1);
    rx_frame(8'hC3, 1'b1, 1'b1);
    rx_frame(8'h99, 1'b1, 1'b0);            // dropped
    bus_read(2'd1, v); check("R5 overrun set", {7'd0, v[3]}, 8'd1);
    pop_check("R5 first entry");
    bus_read(2'd1, v); check("R5 overrun cleared by read", {7'd0, v[3]}, 8'd0);
    check("R6 rxc with one left", {7'd0, v[7]}, 8'd1);
    pop_check("R5 second entry");
    bus_read(2'd1, v); check("R6 rxc empty", {7'd0, v[7]}, 8'd0);
    bus_read(2'd0, v); check("R1 empty read", v, 8'h00);

    // frame error travels with its entry
    rx_frame(8'h77, 1'b0, 1'b1);
    rx_frame(8'h81, 1'b1, 1'b1);
    pop_check("R9 bad stop");
    pop_check("R9 good stop");

    // flush by disabling the receiver
    rx_frame(8'h42, 1'b1, 1'b0);
    bus_read(2'd1, v); check("R6 rxc before flush", {7'd0, v[7]}, 8'd1);
    bus_write(2'd2, 8'hEB);
    bus_read(2'd1, v); check("R6 flushed", {7'd0, v[7]}, 8'd0);
    bus_write(2'd2, 8'hFB);
    bus_read(2'd1, v); check("R6 still empty on re-enable", {7'd0, v[7]}, 8'd0);

    repeat (10) @(posedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule